// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port

This block models one parallel I/O port of a small microcontroller, phase by phase. Each bit has a storage latch that the core writes over its internal bus. The port never drives a pin high. A bit that holds 0 pulls its pin low. A bit that holds 1 releases the pin to a weak pullup, so an outside source can still pull the pin low and the bit then works as an input. The core reads back either the latch contents or the actual pin levels, and it picks which one on each access.

The output stage does not follow the latch at every edge. It tracks the latch only while the machine is in phase 1 of a state, and it holds that value through phase 2. A write made at the end of a machine cycle therefore shows on the pins at the first phase of the next cycle.

A per-bit alternate output is passed to the pin only where the latch holds 1. The real pin level always goes to a per-bit alternate input. When a released bit rises at the start of a machine cycle, a strong-pullup enable is raised for the whole first state to speed up the edge. The clock advances one phase per edge, and the core supplies the current state and phase.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1. Reading the latch returns all ones, no drive-low output is active, and no strong pullup is active.
- R2: When `wr_latch` is 1 at a clock edge, the latch loads `bus_wdata`, and a latch read in the next cycle returns that value.
- R3: `bus_rdata` returns the latch when `rd_latch` is 1, returns the pin levels when only `rd_pin` is 1, and is 0 when neither is 1. `rd_latch` wins when both are 1.
- R4: The output stage is transparent to the latch while `phase` is 0 (P1). While `phase` is 1 (P2) it holds the value the latch had at the end of the preceding P1. A write in the cycle `state`=5 (S6), `phase`=1 reaches `drive_low` in the following S1P1 cycle, where S1 is `state`=0.
- R5: Each bit drives low unless both its buffered latch bit and its `alt_out` bit are 1.
- R6: The pin level is 0 when the bit drives low or when `ext_pull_low` is 1, and 1 otherwise. `alt_in` always carries the pin level.
- R7: A bit whose buffered value in S1P1 is 1, while it was 0 in the preceding S6P2, asserts `strong_pu` during S1P1 and S1P2 of that cycle. `strong_pu` is never active outside S1 and never active on a bit that drives low.
- R8: `weak_pu` is active on exactly the bits that do not drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| state | input | 3 | Current machine state, 0..5 for S1..S6 |
| phase | input | 1 | Current phase, 0 = P1, 1 = P2 |
| wr_latch | input | 1 | Write strobe for the latches |
| bus_wdata | input | WIDTH | Write data from the internal bus |
| rd_latch | input | 1 | Read strobe returning the latches |
| rd_pin | input | 1 | Read strobe returning the pin levels |
| bus_rdata | output | WIDTH | Read data to the internal bus |
| alt_out | input | WIDTH | Per-bit alternate output signal |
| alt_in | output | WIDTH | Per-bit pin level for the alternate input |
| ext_pull_low | input | WIDTH | External source pulling a pin low |
| drive_low | output | WIDTH | Pull-down driver enable |
| weak_pu | output | WIDTH | Weak pullup enable |
| strong_pu | output | WIDTH | Strong pullup enable |
| pin_level | output | WIDTH | Resolved pin level |

## Verification
The bench builds the port with its default WIDTH of 8. At that width, patterns such as 0x0F, 0xA5 and 0x55 put some bits at the rising edge and hold others steady in the same access. This shows in one check that the strong pullup is raised bit by bit and that the alternate-output mask acts per bit. It also lets a pin read differ from a latch read in some bit positions and agree in others.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_S1 = 3'd0;
  localparam logic [STATE_W-1:0] ST_S6 = 3'd5;
  typedef enum logic {PH_1 = 1'b0, PH_2 = 1'b1} phase_e;
endpackage

// File: rtl/qbio_latch_bank.sv
module qbio_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             in_p1,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] held_q,
  output logic [WIDTH-1:0] buf_q
);
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] held_d;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) latch_d = wdata;
    held_d = held_q;
    if (in_p1) held_d = latch_q;
    buf_q = in_p1 ? latch_q : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      held_q  <= '1;
    end else begin
      latch_q <= latch_d;
      held_q  <= held_d;
    end
  end
endmodule

// File: rtl/qbio_boost.sv
module qbio_boost #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_s1,
  input  logic             in_p1,
  input  logic [WIDTH-1:0] buf_q,
  input  logic [WIDTH-1:0] held_q,
  output logic [WIDTH-1:0] boost
);
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] boost_q;
  logic [WIDTH-1:0] boost_d;

  always_comb begin
    rise    = buf_q & ~held_q;
    boost_d = '0;
    if (in_s1 && in_p1)  boost_d = rise;
    if (in_s1 && !in_p1) boost_d = boost_q;
    boost = '0;
    if (in_s1) boost = in_p1 ? rise : boost_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boost_q <= '0;
    else        boost_q <= boost_d;
  end
endmodule

// File: rtl/qbio_pad_cell.sv
module qbio_pad_cell (
  input  logic buf_bit,
  input  logic alt_bit,
  input  logic ext_low,
  input  logic boost_bit,
  output logic drv_low,
  output logic weak_en,
  output logic strong_en,
  output logic level
);
  logic release_pin;

  always_comb begin
    release_pin = buf_bit & alt_bit;
    drv_low     = ~release_pin;
    weak_en     = release_pin;
    strong_en   = boost_bit & release_pin;
    level       = ~(drv_low | ext_low);
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state,
  input  logic               phase,
  input  logic               wr_latch,
  input  logic [WIDTH-1:0]   bus_wdata,
  input  logic               rd_latch,
  input  logic               rd_pin,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   alt_out,
  output logic [WIDTH-1:0]   alt_in,
  input  logic [WIDTH-1:0]   ext_pull_low,
  output logic [WIDTH-1:0]   drive_low,
  output logic [WIDTH-1:0]   weak_pu,
  output logic [WIDTH-1:0]   strong_pu,
  output logic [WIDTH-1:0]   pin_level
);
  logic             in_p1;
  logic             in_s1;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] buf_q;
  logic [WIDTH-1:0] boost;

  assign in_p1 = (phase == PH_1);
  assign in_s1 = (state == ST_S1);

  qbio_latch_bank #(.WIDTH(WIDTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_latch), .wdata(bus_wdata),
    .in_p1(in_p1), .latch_q(latch_q), .held_q(held_q), .buf_q(buf_q)
  );

  qbio_boost #(.WIDTH(WIDTH)) u_boost (
    .clk(clk), .rst_n(rst_n), .in_s1(in_s1), .in_p1(in_p1),
    .buf_q(buf_q), .held_q(held_q), .boost(boost)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_pad
    qbio_pad_cell u_pad (
      .buf_bit(buf_q[b]), .alt_bit(alt_out[b]), .ext_low(ext_pull_low[b]),
      .boost_bit(boost[b]), .drv_low(drive_low[b]), .weak_en(weak_pu[b]),
      .strong_en(strong_pu[b]), .level(pin_level[b])
    );
  end

  assign alt_in = pin_level;

  always_comb begin
    bus_rdata = '0;
    if (rd_latch)    bus_rdata = latch_q;
    else if (rd_pin) bus_rdata = pin_level;
  end
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk
  import qbio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] state,
  input logic               phase,
  input logic               wr_latch,
  input logic [WIDTH-1:0]   bus_wdata,
  input logic               rd_latch,
  input logic [WIDTH-1:0]   bus_rdata,
  input logic [WIDTH-1:0]   alt_out,
  input logic [WIDTH-1:0]   ext_pull_low,
  input logic [WIDTH-1:0]   drive_low,
  input logic [WIDTH-1:0]   strong_pu,
  input logic [WIDTH-1:0]   pin_level
);
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> (!rd_latch || bus_rdata == $past(bus_wdata)));

  // R4
  p2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_2 && $stable(alt_out)) |-> $stable(drive_low));

  // R6
  ext_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & ext_pull_low) == '0);

  // R7
  boost_in_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu != '0) |-> (state == ST_S1));

  // R7
  boost_no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu & drive_low) == '0);
endmodule

bind qbio_port qbio_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_qbio_port.sv
module test_qbio_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] state;
  logic phase;
  logic wr_latch, rd_latch, rd_pin;
  logic [W-1:0] bus_wdata, bus_rdata, alt_out, alt_in, ext_pull_low;
  logic [W-1:0] drive_low, weak_pu, strong_pu, pin_level;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbio_port #(.WIDTH(W)) i_qbio_port (
    .clk(clk), .rst_n(rst_n), .state(state), .phase(phase),
    .wr_latch(wr_latch), .bus_wdata(bus_wdata), .rd_latch(rd_latch),
    .rd_pin(rd_pin), .bus_rdata(bus_rdata), .alt_out(alt_out),
    .alt_in(alt_in), .ext_pull_low(ext_pull_low), .drive_low(drive_low),
    .weak_pu(weak_pu), .strong_pu(strong_pu), .pin_level(pin_level)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one phase forward; inputs change 1 time unit after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    if (phase) begin
      phase = 1'b0;
      state = (state == 3'd5) ? 3'd0 : state + 3'd1;
    end else begin
      phase = 1'b1;
    end
  endtask

  task automatic go_to(logic [2:0] s, logic p);
    tick();
    while (!(state == s && phase == p)) tick();
  endtask

  task automatic write_at(logic [2:0] s, logic p, logic [W-1:0] v);
    go_to(s, p);
    wr_latch = 1'b1;
    bus_wdata = v;
    tick();
    wr_latch = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rd_latch = 1'b1; #1;
    check("R1 latch", bus_rdata, 8'hFF);
    check("R1 drive_low", drive_low, 8'h00);
    check("R1 strong_pu", strong_pu, 8'h00);
    rd_latch = 1'b0;
  endtask

  task automatic t_cycle_edge_write();
    go_to(3'd6 - 3'd1, 1'b1);
    #1;
    check("R4 before write", drive_low, 8'h00);
    wr_latch = 1'b1; bus_wdata = 8'h00;
    tick(); wr_latch = 1'b0; #1;
    check("R4 S1P1 shows new", drive_low, 8'hFF);
    check("R6 pins low", pin_level, 8'h00);
    check("R8 weak off", weak_pu, 8'h00);
    rd_latch = 1'b1; #1;
    check("R2 readback", bus_rdata, 8'h00);
    rd_latch = 1'b0;
  endtask

  task automatic t_boost();
    write_at(3'd5, 1'b1, 8'h0F);
    check("R7 S1P1 boost", strong_pu, 8'h0F);
    check("R5 drive", drive_low, 8'hF0);
    tick(); #1;
    check("R7 S1P2 boost", strong_pu, 8'h0F);
    tick(); #1;
    check("R7 S2P1 no boost", strong_pu, 8'h00);
  endtask

  task automatic t_p1_write();
    write_at(3'd2, 1'b0, 8'hA5);
    check("R4 P2 holds old", drive_low, 8'hF0);
    tick(); #1;
    check("R4 next P1 new", drive_low, 8'h5A);
    go_to(3'd0, 1'b0); #1;
    check("R7 no boost mid-cycle rise", strong_pu, 8'h00);
  endtask

  task automatic t_reads();
    write_at(3'd5, 1'b1, 8'hFF);
    ext_pull_low = 8'h3C; #1;
    rd_pin = 1'b1; #1;
    check("R3 pin read", bus_rdata, 8'hC3);
    check("R6 alt_in", alt_in, 8'hC3);
    rd_latch = 1'b1; #1;
    check("R3 latch priority", bus_rdata, 8'hFF);
    rd_latch = 1'b0; rd_pin = 1'b0; #1;
    check("R3 no read", bus_rdata, 8'h00);
    ext_pull_low = 8'h00;
  endtask

  task automatic t_alt();
    write_at(3'd2, 1'b1, 8'hF0);
    alt_out = 8'h55;
    go_to(3'd4, 1'b0); #1;
    check("R5 alt gating", drive_low, 8'hAF);
    check("R6 alt pins", pin_level, 8'h50);
    check("R8 weak", weak_pu, 8'h50);
    alt_out = 8'hFF;
  endtask

  initial begin
    rst_n = 1'b0; state = 3'd0; phase = 1'b0;
    wr_latch = 1'b0; rd_latch = 1'b0; rd_pin = 1'b0;
    bus_wdata = '0; alt_out = 8'hFF; ext_pull_low = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_cycle_edge_write();
    t_boost();
    t_p1_write();
    t_reads();
    t_alt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule